// File: doc/BRIEF.md
# NAND Common-Memory Access Timing Sequencer

This block shapes one read or one write to the common-memory area of an 8-bit NAND flash device. A host presents a request together with a direction, an address, write data and a 32-bit timing word. The block then steps through three phases. In the setup phase the address is driven and the strobes stay idle. In the command phase one active-low strobe is asserted. In the hold phase the address, and on writes also the data, stay on the pins. When the hold phase ends, the block returns to idle and pulses a done flag.

The timing word carries four 8-bit counts: setup, command wait, hold and write Hi-Z. The block copies the word when it accepts a request. The command phase has a programmed minimum length, and it stretches for as long as the synchronized active-low wait input stays low. Reads hold two cycles longer than writes. On a write, the data-bus output enable stays low for a programmed number of cycles counted from the start of the access. Read data is captured in the final strobe cycle.

Top module: `nand_cmem_seq`

## Requirements
- R1: After a request is accepted, the address is driven for exactly (setup + 1) cycles before a strobe asserts. Setup occupies timing bits [7:0].
- R2: With the wait input high, the strobe stays low for exactly (wait + 1) cycles. Wait occupies timing bits [15:8].
- R3: If the synchronized wait input is low when the command count runs out, the strobe stays low until the synchronized input reads high. The synchronizer adds two cycles of latency.
- R4: After the strobe rises, the block stays busy for (hold) cycles on a write and (hold + 2) cycles on a read. Hold occupies timing bits [23:16]. The address output is steady for the whole access.
- R5: On a write, the data output enable is low for min(Hi-Z, access length) cycles counted from the first busy cycle. Hi-Z occupies timing bits [31:24]. After that the enable is high with the write data on the bus until the access ends. On a read, the enable is never high.
- R6: A write asserts only the active-low write strobe, and a read asserts only the active-low read strobe. Both strobes are high while idle.
- R7: Read data is the value on the data input at the clock edge that ends the last strobe-low cycle.
- R8: The done output is high for exactly one cycle, which is the first idle cycle after an access. The ready output is high only while idle.
- R9: The timing word is copied at acceptance. Changing it during an access does not change that access's phase lengths.
- R10: A write with hold = 0 goes from its last strobe cycle directly to idle.
- R11: During reset and after it, ready is high, both strobes are high, and the output enable and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, accepted when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| timing | input | 32 | {Hi-Z, hold, wait, setup}, each 8 bits |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DW | Captured read data |
| mem_addr | output | AW | Address to the device |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dout | output | DW | Data driven to the device |
| mem_dout_en | output | 1 | Data-bus output enable |
| mem_din | input | DW | Data returned by the device |
| mem_wait_n | input | 1 | Active-low wait from the device (asynchronous) |

## Verification
Every phase length is measured from the cycle after the accepting edge. The first busy cycle is the first one that shows ready low. The bench samples at each falling edge and sorts each busy cycle into pre-strobe, strobe-low or post-strobe. It compares the three counts with (setup + 1), (wait + 1) and hold or hold + 2. It expects done and the captured read data in the first cycle where ready is high again, and expects done to be gone one cycle later. For the wait extension, the input is released in a known strobe cycle n, so the strobe must stay low for n + 3 cycles: two synchronizer edges plus the exit edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int FIELD_W = 8;
    localparam int TIM_W   = 4 * FIELD_W;

    // Timing word layout, most significant field first
    typedef struct packed {
        logic [FIELD_W-1:0] hiz;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] wt;
        logic [FIELD_W-1:0] setup;
    } nand_tim_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_HOLD
    } nand_ph_e;
endpackage

// File: rtl/nand_wait_sync.sv
module nand_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/nand_hiz_timer.sv
module nand_hiz_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = len;
        else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [FIELD_W-1:0] t_setup,
    input  logic [FIELD_W-1:0] t_wait,
    input  logic [FIELD_W-1:0] t_hold,
    input  logic               wait_ok,
    input  logic [DW-1:0]      din,
    input  logic               hiz_over,
    output logic               start,
    output logic               ready,
    output logic               done,
    output logic [DW-1:0]      rdata,
    output logic [AW-1:0]      addr,
    output logic               we_n,
    output logic               oe_n,
    output logic [DW-1:0]      dout,
    output logic               dout_en
);
    localparam int CW = FIELD_W + 1;

    typedef struct packed {
        nand_ph_e           ph;
        logic [CW-1:0]      cnt;
        logic               wr;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      wdata;
        logic [DW-1:0]      rdata;
        logic [FIELD_W-1:0] wt;
        logic [FIELD_W-1:0] hold;
        logic               done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        start     = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    start      = 1'b1;
                    st_d.ph    = PH_SETUP;
                    st_d.cnt   = CW'(t_setup);
                    st_d.wr    = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.wt    = t_wait;
                    st_d.hold  = t_hold;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_CMD;
                    st_d.cnt = CW'(st_q.wt);
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_CMD: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end else if (wait_ok) begin
                    if (st_q.wr) begin
                        if (st_q.hold == '0) begin
                            st_d.ph   = PH_IDLE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.ph  = PH_HOLD;
                            st_d.cnt = CW'(st_q.hold) - CW'(1);
                        end
                    end else begin
                        st_d.rdata = din;
                        st_d.ph    = PH_HOLD;
                        st_d.cnt   = CW'(st_q.hold) + CW'(1);
                    end
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready   = (st_q.ph == PH_IDLE);
    assign done    = st_q.done;
    assign rdata   = st_q.rdata;
    assign addr    = st_q.addr;
    assign we_n    = !((st_q.ph == PH_CMD) && st_q.wr);
    assign oe_n    = !((st_q.ph == PH_CMD) && !st_q.wr);
    assign dout    = st_q.wdata;
    assign dout_en = st_q.wr && (st_q.ph != PH_IDLE) && hiz_over;
endmodule

// File: rtl/nand_cmem_seq.sv
module nand_cmem_seq
    import nand_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [TIM_W-1:0] timing,
    output logic             req_ready,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din,
    input  logic             mem_wait_n
);
    nand_tim_t tim;
    logic      wait_ok;
    logic      start;
    logic      hiz_over;

    assign tim = nand_tim_t'(timing);

    nand_wait_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_wait_n),
        .sync_out (wait_ok)
    );

    nand_hiz_timer #(.W(FIELD_W)) u_hiz (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .len     (tim.hiz),
        .expired (hiz_over)
    );

    nand_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .t_setup   (tim.setup),
        .t_wait    (tim.wt),
        .t_hold    (tim.hold),
        .wait_ok   (wait_ok),
        .din       (mem_din),
        .hiz_over  (hiz_over),
        .start     (start),
        .ready     (req_ready),
        .done      (done),
        .rdata     (rdata),
        .addr      (mem_addr),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dout      (mem_dout),
        .dout_en   (mem_dout_en)
    );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dout_en,
    input logic          wait_ok,
    input logic [AW-1:0] mem_addr
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R6
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_we_n && mem_oe_n));
    // R5
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);
    // R5
    idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_dout_en);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    // R3
    wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_we_n || !mem_oe_n) && !wait_ok) |=> (!mem_we_n || !mem_oe_n));
    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready || $stable(mem_addr)));
endmodule

bind nand_cmem_seq nand_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dout_en (mem_dout_en),
    .wait_ok     (wait_ok),
    .mem_addr    (mem_addr)
);

// File: tb/sim_nand_cmem_seq.sv
module sim_nand_cmem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [31:0]   timing = '0;
    logic          req_ready, done;
    logic [DW-1:0] rdata, mem_dout;
    logic [AW-1:0] mem_addr;
    logic          mem_we_n, mem_oe_n, mem_dout_en;
    logic [DW-1:0] mem_din = '0;
    logic          mem_wait_n = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cmem_seq #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .timing(timing),
        .req_ready(req_ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait_n(mem_wait_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        // R11
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
        check(mem_we_n && mem_oe_n, "R11 strobes", int'({mem_we_n, mem_oe_n}), 3);
        check(!mem_dout_en && !done, "R11 enable/done", int'({mem_dout_en, done}), 0);
    endtask

    // One access; rel >= 0 holds wait low until strobe cycle rel
    task automatic run_access(input bit wr, input int s, input int w, input int h,
                              input int z, input int rel,
                              input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int pre = 0, cmd = 0, post = 0, lowen = 0, guard = 0;
        int exp_cmd, exp_post, exp_hz, total;
        bit bad_strobe = 0, bad_addr = 0, bad_data = 0, rd_drive = 0;
        logic [DW-1:0] last_din = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        timing    = {z[7:0], h[7:0], w[7:0], s[7:0]};
        if (rel >= 0) mem_wait_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        timing    = 32'h5A5A_5A5A; // R9: late change must be ignored
        while (!req_ready && guard < 5000) begin
            guard++;
            if (!mem_we_n || !mem_oe_n) begin
                cmd++;
                if (wr ? (mem_oe_n == 1'b0 || mem_we_n == 1'b1)
                       : (mem_we_n == 1'b0 || mem_oe_n == 1'b1)) bad_strobe = 1;
            end else if (cmd == 0) pre++;
            else post++;
            if (mem_addr != a) bad_addr = 1;
            if (wr && !mem_dout_en) lowen++;
            if (wr && mem_dout_en && mem_dout != wd) bad_data = 1;
            if (!wr && mem_dout_en) rd_drive = 1;
            mem_din = DW'(8'h30 + guard);
            if (!mem_we_n || !mem_oe_n) last_din = mem_din;
            if (rel >= 0 && cmd == rel + 1) mem_wait_n = 1'b1;
            @(negedge clk);
        end
        mem_wait_n = 1'b1;
        exp_cmd  = (rel >= 0 && rel + 3 > w + 1) ? rel + 3 : w + 1;
        exp_post = wr ? h : h + 2;
        total    = s + 1 + exp_cmd + exp_post;
        exp_hz   = (z < total) ? z : total;
        check(pre == s + 1, "R1 setup cycles", pre, s + 1);
        if (rel >= 0) check(cmd == exp_cmd, "R3 extended strobe", cmd, exp_cmd);
        else          check(cmd == exp_cmd, "R2 strobe cycles", cmd, exp_cmd);
        check(post == exp_post, wr ? "R4/R10 write hold" : "R4 read hold", post, exp_post);
        check(!bad_addr, "R4 address steady", int'(bad_addr), 0);
        check(!bad_strobe, "R6 strobe choice", int'(bad_strobe), 0);
        if (wr) begin
            check(lowen == exp_hz, "R5 Hi-Z cycles", lowen, exp_hz);
            check(!bad_data, "R5 write data", int'(bad_data), 0);
        end else begin
            check(!rd_drive, "R5 read no drive", int'(rd_drive), 0);
            check(rdata == last_din, "R7 read data", int'(rdata), int'(last_din));
        end
        check(done == 1'b1, "R8 done at idle", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    task automatic test_write_basic();
        run_access(1'b1, 2, 3, 2, 1, -1, 16'h1234, 8'hC3); // R1 R2 R4 R5 R9
    endtask

    task automatic test_read_basic();
        run_access(1'b0, 1, 2, 1, 4, -1, 16'hBEEF, 8'h00); // R4 R7 R9
    endtask

    task automatic test_write_zero();
        run_access(1'b1, 0, 0, 0, 0, -1, 16'h0F0F, 8'h5A); // R10
    endtask

    task automatic test_read_zero_hold();
        run_access(1'b0, 0, 0, 0, 0, -1, 16'h00FF, 8'h00); // R4
    endtask

    task automatic test_wait_read();
        run_access(1'b0, 0, 2, 0, 0, 4, 16'hA5A5, 8'h00); // R3
    endtask

    task automatic test_wait_write();
        run_access(1'b1, 3, 1, 1, 2, 3, 16'h4321, 8'h99); // R3
    endtask

    task automatic test_long_hiz();
        run_access(1'b1, 1, 1, 1, 40, -1, 16'h7777, 8'h11); // R5
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        test_reset();
        rst_n = 1'b1;
        test_reset();
        test_write_basic();
        test_read_basic();
        test_write_zero();
        test_read_zero_hold();
        test_wait_read();
        test_wait_write();
        test_long_hiz();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule